// File: doc/BRIEF.md
# JTAG Test Access Port with External Scan-Chain Clocking

This block is a test access port controller that runs in a fast system clock domain. It oversamples the JTAG pins TCK, TMS, TDI and TRST, and runs the 16-state test controller on each detected TCK rising edge. The current controller state is visible on a 4-bit bus. A 4-bit instruction register selects one of four data paths for the serial scan: a 32-bit identification register loaded from an input port, a single-bit bypass cell, a 4-bit chain-number register, or an off-block boundary scan chain.

For that off-block chain the block produces two shift clocks: a master clock during the high half of TCK and a slave clock during the low half. They run only while the controller sits in Shift-DR with chain number 3 selected. It also derives two non-overlapping TCK phase signals. The serial output of the chain is sampled on TCK rising edges and returned on TDO. TDO changes on TCK falling edges and is enabled only during the two shift states.

All pin inputs pass through a `SYNC_STAGES`-deep synchronizer. Each output settles within `SYNC_STAGES + 2` system clocks of the TCK edge that causes it.

Top module: `tap_xscan_ctrl`

## Requirements
- R1: `tap_state` follows the IEEE 1149.1 TMS transitions, one step per TCK rising edge, and holds between rises. The encoding is: 0 Exit2-DR, 1 Exit1-DR, 2 Shift-DR, 3 Pause-DR, 4 Select-IR, 5 Update-DR, 6 Capture-DR, 7 Select-DR, 8 Exit2-IR, 9 Exit1-IR, A Shift-IR, B Pause-IR, C Run-Test/Idle, D Update-IR, E Capture-IR, F Test-Logic-Reset.
- R2: `rst` or `trst` forces state F. Five TCK rises with TMS high reach F from any state.
- R3: Capture-IR loads 4'hE (IDCODE) into the instruction shifter. Shift-IR moves it out LSB first. Update-IR commits it. State F restores IDCODE. The opcodes are: EXTEST 4'h0, chain select 4'h2, INTEST 4'hC, IDCODE 4'hE, BYPASS 4'hF.
- R4: Under IDCODE, Capture-DR loads `dev_id`, and Shift-DR presents it on TDO LSB first.
- R5: Under BYPASS, and under any opcode not listed in R3, the data path is one cell. It captures 0 and returns TDI one TCK later.
- R6: Under chain select, a 4-bit register captures the current chain number, shifts LSB first, and loads the chain number in Update-DR. State F clears the chain number to 0.
- R7: Under EXTEST or INTEST with chain 3, TDO returns `xchain_so` as sampled at the previous TCK rise in Capture-DR or Shift-DR. With any other chain, these opcodes behave as bypass.
- R8: TDO and `tdo_oe` change only after TCK falls. In Shift-IR/Shift-DR the enable is 1. Elsewhere TDO is 0 and the enable is 0.
- R9: `ph1` is high while TCK is high and `ph2` is high while TCK is low. They are never high together.
- R10: `xshift_clk1` equals `ph1` and `xshift_clk2` equals `ph2` while the state is Shift-DR and the chain number is 3. Otherwise both are low.
- R11: `xchain_si` follows the synchronized TDI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the JTAG pins |
| rst | input | 1 | Synchronous active-high reset |
| trst | input | 1 | Test reset, active high, forces Test-Logic-Reset |
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| dev_id | input | ID_W | Identification value captured under IDCODE |
| xchain_so | input | 1 | Serial output of the external chain (tie low if absent) |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for TDO |
| tap_state | output | 4 | Current controller state |
| ph1 | output | 1 | TCK high-phase signal |
| ph2 | output | 1 | TCK low-phase signal |
| xshift_clk1 | output | 1 | Master-half shift clock for the external chain |
| xshift_clk2 | output | 1 | Slave-half shift clock for the external chain |
| xchain_si | output | 1 | Serial data into the external chain |

## Verification
The bench aims at the one-TCK offsets on TDO: the first bypass bit must be the captured 0, and the first external-chain bit must be the value sampled during Capture-DR. A design that captured late, or drove TDO on the rising edge, would show every bit shifted by one position. It checks the gated shift clocks in both halves of every TCK cycle, including the half-cycle on entry to Shift-DR and the one after leaving it, and with a chain other than 3 selected. A gate that was off by a state or ignored the chain number would clock the external cells at the wrong time. It also checks that Test-Logic-Reset, reached by five TMS-high edges or by TRST, restores IDCODE and clears the chain number. A design that skipped this would return stale chain or opcode data after reset.

// File: rtl/tap_xscan_pkg.sv
`timescale 1ns/1ps
package tap_xscan_pkg;

  typedef enum logic [3:0] {
    ST_EX2_DR   = 4'h0,
    ST_EX1_DR   = 4'h1,
    ST_SHIFT_DR = 4'h2,
    ST_PAUSE_DR = 4'h3,
    ST_SEL_IR   = 4'h4,
    ST_UPD_DR   = 4'h5,
    ST_CAP_DR   = 4'h6,
    ST_SEL_DR   = 4'h7,
    ST_EX2_IR   = 4'h8,
    ST_EX1_IR   = 4'h9,
    ST_SHIFT_IR = 4'hA,
    ST_PAUSE_IR = 4'hB,
    ST_IDLE     = 4'hC,
    ST_UPD_IR   = 4'hD,
    ST_CAP_IR   = 4'hE,
    ST_RESET    = 4'hF
  } tap_state_e;

  // One controller step for a given TMS level.
  function automatic tap_state_e tap_next(input tap_state_e cur, input logic mode);
    tap_state_e nxt;
    case (cur)
      ST_RESET:    nxt = mode ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = mode ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   nxt = mode ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nxt = mode ? ST_EX1_DR   : ST_SHIFT_DR;
      ST_SHIFT_DR: nxt = mode ? ST_EX1_DR   : ST_SHIFT_DR;
      ST_EX1_DR:   nxt = mode ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nxt = mode ? ST_EX2_DR   : ST_PAUSE_DR;
      ST_EX2_DR:   nxt = mode ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   nxt = mode ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   nxt = mode ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   nxt = mode ? ST_EX1_IR   : ST_SHIFT_IR;
      ST_SHIFT_IR: nxt = mode ? ST_EX1_IR   : ST_SHIFT_IR;
      ST_EX1_IR:   nxt = mode ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nxt = mode ? ST_EX2_IR   : ST_PAUSE_IR;
      ST_EX2_IR:   nxt = mode ? ST_UPD_IR   : ST_SHIFT_IR;
      default:     nxt = mode ? ST_SEL_DR   : ST_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/tap_pin_sync.sv
`timescale 1ns/1ps
module tap_pin_sync #(
  parameter int STAGES = 2,
  parameter int W      = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= pin_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/tap_clk_phase.sv
`timescale 1ns/1ps
module tap_clk_phase (
  input  logic clk,
  input  logic rst,
  input  logic tck_s,
  input  logic shift_gate,
  output logic tck_rise,
  output logic tck_fall,
  output logic ph1,
  output logic ph2,
  output logic sh1,
  output logic sh2
);
  logic tck_prev;
  logic hi_steady, lo_steady;

  assign tck_rise  =  tck_s & ~tck_prev;
  assign tck_fall  = ~tck_s &  tck_prev;
  // Both samples must agree, so each edge leaves one clock with both phases low.
  assign hi_steady =  tck_s &  tck_prev;
  assign lo_steady = ~tck_s & ~tck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      tck_prev <= 1'b0;
      ph1      <= 1'b0;
      ph2      <= 1'b0;
      sh1      <= 1'b0;
      sh2      <= 1'b0;
    end else begin
      tck_prev <= tck_s;
      ph1      <= hi_steady;
      ph2      <= lo_steady;
      sh1      <= hi_steady & shift_gate;
      sh2      <= lo_steady & shift_gate;
    end
  end
endmodule

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tap_xscan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       trst_s,
  input  logic       tck_rise,
  input  logic       tms_s,
  output tap_state_e state_q
);
  always_ff @(posedge clk) begin
    if (rst || trst_s)  state_q <= ST_RESET;
    else if (tck_rise)  state_q <= tap_next(state_q, tms_s);
  end
endmodule

// File: rtl/tap_data_path.sv
`timescale 1ns/1ps
module tap_data_path
  import tap_xscan_pkg::*;
#(
  parameter int                ID_W        = 32,
  parameter int                IR_W        = 4,
  parameter int                SEL_W       = 4,
  parameter logic [SEL_W-1:0]  EXT_CHAIN   = 3,
  parameter logic [IR_W-1:0]   OP_EXTEST   = 4'h0,
  parameter logic [IR_W-1:0]   OP_SCAN_SEL = 4'h2,
  parameter logic [IR_W-1:0]   OP_INTEST   = 4'hC,
  parameter logic [IR_W-1:0]   OP_IDCODE   = 4'hE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tck_rise,
  input  logic             tck_fall,
  input  tap_state_e       state,
  input  logic             tdi_s,
  input  logic             xso_s,
  input  logic [ID_W-1:0]  dev_id,
  output logic             tdo,
  output logic             tdo_oe,
  output logic [SEL_W-1:0] chain_q,
  output logic             xchain_si
);
  logic [IR_W-1:0]  ir_q, ir_sr;
  logic [ID_W-1:0]  id_sr;
  logic [SEL_W-1:0] sel_sr;
  logic             byp_q, ext_q;
  logic             dr_bit;

  always_comb begin
    if (ir_q == OP_IDCODE)                             dr_bit = id_sr[0];
    else if (ir_q == OP_SCAN_SEL)                      dr_bit = sel_sr[0];
    else if ((ir_q == OP_EXTEST) || (ir_q == OP_INTEST))
                                                       dr_bit = (chain_q == EXT_CHAIN) ? ext_q : byp_q;
    else                                               dr_bit = byp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q      <= OP_IDCODE;
      ir_sr     <= OP_IDCODE;
      chain_q   <= '0;
      id_sr     <= '0;
      sel_sr    <= '0;
      byp_q     <= 1'b0;
      ext_q     <= 1'b0;
      tdo       <= 1'b0;
      tdo_oe    <= 1'b0;
      xchain_si <= 1'b0;
    end else begin
      xchain_si <= tdi_s;
      if (state == ST_RESET) begin
        ir_q    <= OP_IDCODE;
        chain_q <= '0;
      end
      if (tck_rise) begin
        case (state)
          ST_CAP_IR:   ir_sr <= OP_IDCODE;
          ST_SHIFT_IR: ir_sr <= {tdi_s, ir_sr[IR_W-1:1]};
          ST_UPD_IR:   ir_q  <= ir_sr;
          ST_CAP_DR: begin
            id_sr  <= dev_id;
            byp_q  <= 1'b0;
            sel_sr <= chain_q;
            ext_q  <= xso_s;
          end
          ST_SHIFT_DR: begin
            id_sr  <= {tdi_s, id_sr[ID_W-1:1]};
            sel_sr <= {tdi_s, sel_sr[SEL_W-1:1]};
            byp_q  <= tdi_s;
            ext_q  <= xso_s;
          end
          ST_UPD_DR: if (ir_q == OP_SCAN_SEL) chain_q <= sel_sr;
          default: ;
        endcase
      end
      if (tck_fall) begin
        case (state)
          ST_SHIFT_IR: begin tdo <= ir_sr[0]; tdo_oe <= 1'b1; end
          ST_SHIFT_DR: begin tdo <= dr_bit;   tdo_oe <= 1'b1; end
          default:     begin tdo <= 1'b0;     tdo_oe <= 1'b0; end
        endcase
      end
    end
  end
endmodule

// File: rtl/tap_xscan_ctrl.sv
`timescale 1ns/1ps
module tap_xscan_ctrl
  import tap_xscan_pkg::*;
#(
  parameter int               ID_W        = 32,
  parameter int               IR_W        = 4,
  parameter int               SEL_W       = 4,
  parameter int               SYNC_STAGES = 2,
  parameter logic [SEL_W-1:0] EXT_CHAIN   = 3,
  parameter logic [IR_W-1:0]  OP_EXTEST   = 4'h0,
  parameter logic [IR_W-1:0]  OP_SCAN_SEL = 4'h2,
  parameter logic [IR_W-1:0]  OP_INTEST   = 4'hC,
  parameter logic [IR_W-1:0]  OP_IDCODE   = 4'hE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trst,
  input  logic            tck,
  input  logic            tms,
  input  logic            tdi,
  input  logic [ID_W-1:0] dev_id,
  input  logic            xchain_so,
  output logic            tdo,
  output logic            tdo_oe,
  output logic [3:0]      tap_state,
  output logic            ph1,
  output logic            ph2,
  output logic            xshift_clk1,
  output logic            xshift_clk2,
  output logic            xchain_si
);
  localparam int PIN_W = 5;

  logic [PIN_W-1:0] pin_raw, pin_s;
  logic             tck_s, tms_s, tdi_s, xso_s, trst_s;
  logic             tck_rise, tck_fall;
  logic             ext_shift;
  logic [SEL_W-1:0] chain_q;
  tap_state_e       st_q;

  assign pin_raw = {trst, xchain_so, tdi, tms, tck};
  assign {trst_s, xso_s, tdi_s, tms_s, tck_s} = pin_s;

  tap_pin_sync #(.STAGES(SYNC_STAGES), .W(PIN_W)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_raw),
    .pin_sync (pin_s)
  );

  assign ext_shift = (st_q == ST_SHIFT_DR) && (chain_q == EXT_CHAIN);

  tap_clk_phase u_phase (
    .clk        (clk),
    .rst        (rst),
    .tck_s      (tck_s),
    .shift_gate (ext_shift),
    .tck_rise   (tck_rise),
    .tck_fall   (tck_fall),
    .ph1        (ph1),
    .ph2        (ph2),
    .sh1        (xshift_clk1),
    .sh2        (xshift_clk2)
  );

  tap_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .trst_s   (trst_s),
    .tck_rise (tck_rise),
    .tms_s    (tms_s),
    .state_q  (st_q)
  );

  assign tap_state = st_q;

  tap_data_path #(
    .ID_W        (ID_W),
    .IR_W        (IR_W),
    .SEL_W       (SEL_W),
    .EXT_CHAIN   (EXT_CHAIN),
    .OP_EXTEST   (OP_EXTEST),
    .OP_SCAN_SEL (OP_SCAN_SEL),
    .OP_INTEST   (OP_INTEST),
    .OP_IDCODE   (OP_IDCODE)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .tck_rise  (tck_rise),
    .tck_fall  (tck_fall),
    .state     (st_q),
    .tdi_s     (tdi_s),
    .xso_s     (xso_s),
    .dev_id    (dev_id),
    .tdo       (tdo),
    .tdo_oe    (tdo_oe),
    .chain_q   (chain_q),
    .xchain_si (xchain_si)
  );
endmodule

// File: rtl/tap_xscan_chk.sv
`timescale 1ns/1ps
module tap_xscan_chk #(
  parameter int               SEL_W     = 4,
  parameter logic [SEL_W-1:0] EXT_CHAIN = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             trst_s,
  input logic             tck_rise,
  input logic [3:0]       tap_state,
  input logic [SEL_W-1:0] chain,
  input logic             ph1,
  input logic             ph2,
  input logic             sh1,
  input logic             sh2,
  input logic             tdo_oe
);
  // R1
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tck_rise && !trst_s) |=> $stable(tap_state));

  // R2
  trst_reset_chk: assert property (@(posedge clk) disable iff (rst)
    trst_s |=> (tap_state == 4'hF));

  // R8
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tdo_oe) |-> (tap_state == 4'h2 || tap_state == 4'hA));

  // R9
  no_phase_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(ph1 && ph2));

  // R10
  master_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (sh1 && !$past(trst_s)) |-> (tap_state == 4'h2 && chain == EXT_CHAIN));

  // R10
  slave_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (sh2 && !$past(trst_s)) |-> (tap_state == 4'h2 && chain == EXT_CHAIN));
endmodule

bind tap_xscan_ctrl tap_xscan_chk #(.SEL_W(SEL_W), .EXT_CHAIN(EXT_CHAIN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .trst_s    (trst_s),
  .tck_rise  (tck_rise),
  .tap_state (tap_state),
  .chain     (chain_q),
  .ph1       (ph1),
  .ph2       (ph2),
  .sh1       (xshift_clk1),
  .sh2       (xshift_clk2),
  .tdo_oe    (tdo_oe)
);

// File: tb/tap_xscan_ctrl_test.sv
`timescale 1ns/1ps
module tap_xscan_ctrl_test;
  localparam int HALF = 8;
  localparam logic [31:0] ID_VAL = 32'hC3A5_0F96;

  // {tms, expected state after the rise}
  localparam logic [4:0] WALK [32] = '{
    {1'b0,4'hC},{1'b0,4'hC},{1'b1,4'h7},{1'b0,4'h6},{1'b0,4'h2},{1'b0,4'h2},
    {1'b1,4'h1},{1'b0,4'h3},{1'b0,4'h3},{1'b1,4'h0},{1'b1,4'h5},{1'b0,4'hC},
    {1'b1,4'h7},{1'b1,4'h4},{1'b0,4'hE},{1'b0,4'hA},{1'b0,4'hA},{1'b1,4'h9},
    {1'b0,4'hB},{1'b1,4'h8},{1'b0,4'hA},{1'b1,4'h9},{1'b1,4'hD},{1'b1,4'h7},
    {1'b0,4'h6},{1'b1,4'h1},{1'b1,4'h5},{1'b1,4'h7},{1'b1,4'h4},{1'b1,4'hF},
    {1'b1,4'hF},{1'b0,4'hC}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, trst, tck, tms, tdi, xso;
  logic tdo, tdo_oe, ph1, ph2, xsh1, xsh2, xsi;
  logic [3:0] tap_state;

  tap_xscan_ctrl uut (
    .clk(clk), .rst(rst), .trst(trst), .tck(tck), .tms(tms), .tdi(tdi),
    .dev_id(ID_VAL), .xchain_so(xso), .tdo(tdo), .tdo_oe(tdo_oe),
    .tap_state(tap_state), .ph1(ph1), .ph2(ph2), .xshift_clk1(xsh1),
    .xshift_clk2(xsh2), .xchain_si(xsi)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [3:0] model_st;
  int model_chain;
  logic lo_tdo, lo_oe;
  logic got [64];
  logic got_oe [64];
  logic got_ir [4];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nxt(input logic [3:0] s, input logic m);
    case (s)
      4'hF: return m ? 4'hF : 4'hC;
      4'hC: return m ? 4'h7 : 4'hC;
      4'h7: return m ? 4'h4 : 4'h6;
      4'h6: return m ? 4'h1 : 4'h2;
      4'h2: return m ? 4'h1 : 4'h2;
      4'h1: return m ? 4'h5 : 4'h3;
      4'h3: return m ? 4'h0 : 4'h3;
      4'h0: return m ? 4'h5 : 4'h2;
      4'h5: return m ? 4'h7 : 4'hC;
      4'h4: return m ? 4'hF : 4'hE;
      4'hE: return m ? 4'h9 : 4'hA;
      4'hA: return m ? 4'h9 : 4'hA;
      4'h9: return m ? 4'hD : 4'hB;
      4'hB: return m ? 4'h8 : 4'hB;
      4'h8: return m ? 4'hD : 4'hA;
      default: return m ? 4'h7 : 4'hC;
    endcase
  endfunction

  // One TCK cycle: low half with sampling, then high half with sampling.
  task automatic pulse(input logic m, input logic d, input logic x);
    logic gate;
    tms = m; tdi = d; xso = x;
    repeat (HALF) @(negedge clk);
    gate = (model_st == 4'h2) && (model_chain == 3);
    lo_tdo = tdo; lo_oe = tdo_oe;
    check(ph2 === 1'b1 && ph1 === 1'b0, "R9 low half", {ph1, ph2}, 2'b01);
    check(xsh2 === gate && xsh1 === 1'b0, "R10 slave clock", {xsh1, xsh2}, {1'b0, gate});
    check(xsi === d, "R11 chain input", xsi, d);
    tck = 1'b1;
    model_st = nxt(model_st, m);
    if (model_st == 4'hF) model_chain = 0;
    repeat (HALF) @(negedge clk);
    gate = (model_st == 4'h2) && (model_chain == 3);
    check(tap_state === model_st, "R1 state", tap_state, model_st);
    check(ph1 === 1'b1 && ph2 === 1'b0, "R9 high half", {ph1, ph2}, 2'b10);
    check(xsh1 === gate && xsh2 === 1'b0, "R10 master clock", {xsh1, xsh2}, {gate, 1'b0});
    tck = 1'b0;
  endtask

  // From Run-Test/Idle back to Run-Test/Idle through an IR scan.
  task automatic shift_ir(input logic [3:0] op);
    pulse(1, 0, 0); pulse(1, 0, 0); pulse(0, 0, 0); pulse(0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      pulse(i == 3, op[i], 0);
      got_ir[i] = lo_tdo;
    end
    pulse(1, 0, 0); pulse(0, 0, 0);
  endtask

  // From Run-Test/Idle back to Run-Test/Idle through a DR scan of n bits.
  task automatic shift_dr(input int n, input logic [63:0] din, input logic [63:0] xin, input logic xcap);
    pulse(1, 0, 0); pulse(0, 0, 0); pulse(0, 0, xcap);
    for (int i = 0; i < n; i++) begin
      pulse(i == n - 1, din[i], xin[i]);
      got[i] = lo_tdo;
      got_oe[i] = lo_oe;
    end
    pulse(1, 0, 0); pulse(0, 0, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; trst = 1'b0; tck = 1'b0; tms = 1'b1; tdi = 1'b0; xso = 1'b0;
    model_st = 4'hF; model_chain = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (HALF) @(negedge clk);
    // R2 reset state, R8 idle TDO, R10 clocks low
    check(tap_state === 4'hF, "R2 reset state", tap_state, 4'hF);
    check(tdo_oe === 1'b0 && tdo === 1'b0, "R8 idle after reset", {tdo_oe, tdo}, 2'b00);
    check(xsh1 === 1'b0 && xsh2 === 1'b0, "R10 clocks after reset", {xsh1, xsh2}, 2'b00);

    // R1 transition table walk
    for (int i = 0; i < 32; i++) begin
      pulse(WALK[i][4], 1'b0, 1'b0);
      check(tap_state === WALK[i][3:0], "R1 table", tap_state, WALK[i][3:0]);
    end

    // R4 identification readout (IR is IDCODE after Test-Logic-Reset)
    shift_dr(32, 64'h0, 64'h0, 1'b0);
    for (int i = 0; i < 32; i++) begin
      check(got[i] === ID_VAL[i], "R4 id bit", got[i], ID_VAL[i]);
      check(got_oe[i] === 1'b1, "R8 enable in shift", got_oe[i], 1'b1);
    end
    pulse(0, 0, 0);
    check(lo_oe === 1'b0 && lo_tdo === 1'b0, "R8 idle outside shift", {lo_oe, lo_tdo}, 2'b00);

    // R3 capture value and R5 bypass
    shift_ir(4'hF);
    check({got_ir[3], got_ir[2], got_ir[1], got_ir[0]} === 4'hE, "R3 IR capture",
          {got_ir[3], got_ir[2], got_ir[1], got_ir[0]}, 4'hE);
    shift_dr(6, 64'b101101, 64'h0, 1'b0);
    check(got[0] === 1'b0, "R5 bypass capture", got[0], 1'b0);
    for (int i = 1; i < 6; i++) begin
      logic [63:0] pat;
      pat = 64'b101101;
      check(got[i] === pat[i-1], "R5 bypass delay", got[i], pat[i-1]);
    end
    shift_ir(4'h5);
    shift_dr(3, 64'b011, 64'h0, 1'b0);
    check(got[0] === 1'b0 && got[1] === 1'b1 && got[2] === 1'b1, "R5 undefined opcode",
          {got[2], got[1], got[0]}, 3'b110);

    // R6 chain select: capture shows the old number, then the new one
    shift_ir(4'h2);
    shift_dr(4, 64'h3, 64'h0, 1'b0);
    check({got[3], got[2], got[1], got[0]} === 4'h0, "R6 initial chain",
          {got[3], got[2], got[1], got[0]}, 4'h0);
    model_chain = 3;
    shift_dr(4, 64'h3, 64'h0, 1'b0);
    check({got[3], got[2], got[1], got[0]} === 4'h3, "R6 chain readback",
          {got[3], got[2], got[1], got[0]}, 4'h3);

    // R7 external chain under EXTEST then INTEST (R10 checked inside every pulse)
    shift_ir(4'h0);
    shift_dr(8, 64'h0, 64'b10011011, 1'b1);
    check(got[0] === 1'b1, "R7 capture sample", got[0], 1'b1);
    for (int i = 1; i < 8; i++) begin
      logic [63:0] xp;
      xp = 64'b10011011;
      check(got[i] === xp[i-1], "R7 external bit", got[i], xp[i-1]);
    end
    shift_ir(4'hC);
    shift_dr(4, 64'h0, 64'b0110, 1'b0);
    check({got[3], got[2], got[1], got[0]} === 4'b1100, "R7 intest path",
          {got[3], got[2], got[1], got[0]}, 4'b1100);

    // R7 other chain behaves as bypass, R10 clocks stay low
    shift_ir(4'h2);
    shift_dr(4, 64'h5, 64'h0, 1'b0);
    model_chain = 5;
    shift_ir(4'h0);
    shift_dr(4, 64'b1010, 64'hF, 1'b1);
    check({got[3], got[2], got[1], got[0]} === 4'b0100, "R7 non-external chain",
          {got[3], got[2], got[1], got[0]}, 4'b0100);

    // R2 five TMS-high edges from Shift-DR
    pulse(1, 0, 0); pulse(0, 0, 0); pulse(0, 0, 0);
    for (int i = 0; i < 5; i++) pulse(1, 0, 0);
    check(tap_state === 4'hF, "R2 five ones", tap_state, 4'hF);
    pulse(0, 0, 0);
    // R6 chain cleared by Test-Logic-Reset
    shift_ir(4'h2);
    shift_dr(4, 64'h0, 64'h0, 1'b0);
    check({got[3], got[2], got[1], got[0]} === 4'h0, "R6 chain cleared",
          {got[3], got[2], got[1], got[0]}, 4'h0);

    // R2 test reset pin, then R3 IDCODE restored
    trst = 1'b1;
    repeat (6) @(negedge clk);
    trst = 1'b0;
    repeat (HALF) @(negedge clk);
    check(tap_state === 4'hF, "R2 trst", tap_state, 4'hF);
    model_st = 4'hF; model_chain = 0;
    pulse(0, 0, 0);
    shift_dr(8, 64'h0, 64'h0, 1'b0);
    for (int i = 0; i < 8; i++)
      check(got[i] === ID_VAL[i], "R3 IDCODE after reset", got[i], ID_VAL[i]);

    finish_run();
  end
endmodule